// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns one warp's load request into the smallest set of aligned 128-byte memory transactions. A request has one byte address for each of the 32 lanes and a mask that marks the active lanes. The block sorts the active lanes by the 128-byte line their address falls in. For each distinct line it issues one transaction, which carries the line number and the mask of lanes served by that line. Each lane also gets back its byte offset within its line. Because lanes are grouped by line, any order of lanes inside one line costs one transaction, and fully scattered lanes cost one transaction each.

A request enters through a valid/ready handshake. The block then takes one cycle to capture it, and after that offers transactions on a second valid/ready handshake, one per cycle. Transactions come out in the order of the lowest-numbered active lane that is still unserved. After the last transaction is taken, a one-cycle done pulse reports how many transactions were issued.

The controller has three states. ST_IDLE accepts a request. From there, ST_IDLE goes to ST_ISSUE when the mask is nonzero and to ST_DONE when it is zero. ST_ISSUE offers transactions and stays in place until the handshake that serves the last pending lanes, then moves to ST_DONE. ST_DONE pulses done for one cycle and always returns to ST_IDLE.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, txn_valid is 0 and done is 0.
- R2: req_ready is 1 only in the idle state. A request is taken on a clock edge where req_valid and req_ready are both 1. The first transaction is offered in the cycle right after that edge.
- R3: A transaction's line number is address bits [31:7] of its leading lane. Its lane mask has bit i set exactly for each unserved active lane i whose address bits [31:7] equal that line number. Lane i's address sits at req_addr[32*i+31:32*i].
- R4: Transactions are issued in order of the lowest-numbered active lane not yet served. That lane is the leading lane.
- R5: 32 consecutive 4-byte addresses from a 128-byte-aligned base give one transaction with all lanes. So does any permutation of lanes that stays inside one line.
- R6: A stride of two 4-byte elements across the warp from an aligned base gives exactly two transactions: lanes 0-15, then lanes 16-31.
- R7: Lanes that all fall in different lines give one transaction per lane, up to 32.
- R8: Lanes whose mask bit is 0 appear in no transaction and do not affect the count. A request with an all-zero mask raises done in the cycle after acceptance, with count 0 and no transaction.
- R9: While txn_valid is 1 and txn_ready is 0, txn_line and txn_lanes hold steady. The block moves to the next transaction only on a handshake.
- R10: done is a one-cycle pulse in the cycle after the handshake of the last transaction. While done is 1, txn_count equals the number of transactions issued. In the following cycle req_ready is 1 again.
- R11: lane_offset[7*i+6:7*i] equals address bits [6:0] of lane i. The value is valid from the cycle after capture until the next request is accepted, whatever req_addr does meanwhile.
- R12: With txn_ready held at 1, a request that touches N distinct lines occupies N+1 cycles from acceptance to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| req_mask | input | 32 | Active-lane mask |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken by the memory side |
| txn_line | output | 25 | Line number (address bits [31:7]) |
| txn_lanes | output | 32 | Lanes served by this transaction |
| lane_offset | output | 224 | Per-lane byte offset in its line, lane i in bits [7*i+6:7*i] |
| done | output | 1 | One-cycle pulse after the last transaction |
| txn_count | output | 6 | Number of transactions, valid with done |

## Verification
The assertions take two things for granted. First, the memory side may hold txn_ready low for any number of cycles. Second, a new request is only offered while req_ready is high, because nothing is captured otherwise. The bench respects both of these. It raises req_valid only after it has checked that req_ready is 1. It then drops req_valid one cycle later and overwrites req_addr, so the captured offsets can be shown to ignore the live inputs. Stall patterns on txn_ready exercise the hold rule. A behavioural line-grouping model predicts each transaction in every cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cap,
    input  logic [LANES*ADDR_W-1:0]          addr_in,
    input  logic [LANES-1:0]                 mask_in,
    input  logic [LANES-1:0]                 clear,
    output logic [LANES-1:0][LINE_W-1:0]     lines,
    output logic [LANES-1:0][OFF_W-1:0]      offs,
    output logic [LANES-1:0]                 pending
);
    // Per-lane storage of the captured line number and byte offset.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines[g] <= '0;
                offs[g]  <= '0;
            end else if (cap) begin
                lines[g] <= addr_in[g*ADDR_W+OFF_W +: LINE_W];
                offs[g]  <= addr_in[g*ADDR_W +: OFF_W];
            end
        end
    end

    // Lanes still waiting for a transaction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pending <= '0;
        else if (cap) pending <= mask_in;
        else          pending <= pending & ~clear;
    end
endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][LINE_W-1:0] lines,
    input  logic [LANES-1:0]             pending,
    output logic [LINE_W-1:0]            lead_line,
    output logic [LANES-1:0]             match
);
    logic [SEL_W-1:0] sel;

    // Lowest-numbered pending lane leads the transaction.
    always_comb begin
        sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) sel = SEL_W'(i);
        end
    end

    assign lead_line = lines[sel];

    // Every pending lane sharing the leading line joins it.
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = pending[g] && (lines[g] == lead_line);
    end
endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl
    import coal_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             mask_any,
    input  logic             txn_ready,
    input  logic             more_left,
    output logic             req_ready,
    output logic             cap,
    output logic             txn_valid,
    output logic             fire,
    output logic             done,
    output logic [CNT_W-1:0] txn_count
);
    coal_state_e state, state_nx;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = mask_any ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (fire && !more_left) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: txn_valid = 1'b1;
            ST_DONE:  done      = 1'b1;
            default:  ;
        endcase
    end

    assign cap  = req_valid && req_ready;
    assign fire = txn_valid && txn_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    txn_count <= '0;
        else if (cap)  txn_count <= '0;
        else if (fire) txn_count <= txn_count + 1'b1;
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [LINE_W-1:0]       txn_line,
    output logic [LANES-1:0]        txn_lanes,
    output logic [LANES*OFF_W-1:0]  lane_offset,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);
    logic                          cap, fire, more_left;
    logic [LANES-1:0][LINE_W-1:0]  lines;
    logic [LANES-1:0][OFF_W-1:0]   offs;
    logic [LANES-1:0]              pending, match, clear;

    coal_lane_store #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cap(cap), .addr_in(req_addr), .mask_in(req_mask),
        .clear(clear), .lines(lines), .offs(offs), .pending(pending)
    );

    coal_pick #(.LANES(LANES), .LINE_W(LINE_W)) u_pick (
        .lines(lines), .pending(pending), .lead_line(txn_line), .match(match)
    );

    coal_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mask_any(|req_mask),
        .txn_ready(txn_ready), .more_left(more_left), .req_ready(req_ready),
        .cap(cap), .txn_valid(txn_valid), .fire(fire), .done(done),
        .txn_count(txn_count)
    );

    assign clear       = fire ? match : '0;
    assign more_left   = |(pending & ~match);
    assign txn_lanes   = txn_valid ? match : '0;
    assign lane_offset = offs;
endmodule

// File: rtl/coalescer_checks.sv
module coalescer_checks #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25,
    parameter int OFF_W  = 7,
    parameter int CNT_W  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [LANES-1:0]       req_mask,
    input logic                   txn_valid,
    input logic                   txn_ready,
    input logic [LINE_W-1:0]      txn_line,
    input logic [LANES-1:0]       txn_lanes,
    input logic [LANES*OFF_W-1:0] lane_offset,
    input logic                   done,
    input logic [CNT_W-1:0]       txn_count
);
    logic [LANES-1:0] seen_mask;
    logic [CNT_W-1:0] seen_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_mask <= '0;
            seen_cnt  <= '0;
        end else if (req_valid && req_ready) begin
            seen_mask <= req_mask;
            seen_cnt  <= '0;
        end else if (txn_valid && txn_ready) begin
            seen_cnt  <= seen_cnt + 1'b1;
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (req_ready && !txn_valid && !done));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done) |-> !req_ready);

    a_r2_first_txn_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask != '0) |=> txn_valid);

    a_r3_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_lanes != '0);

    a_r8_lanes_active_only: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes & ~seen_mask) == '0);

    a_r8_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> (done && txn_count == '0));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_lanes)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r10_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txn_count == seen_cnt);

    a_r11_offsets_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(lane_offset));
endmodule

bind warp_coalescer coalescer_checks #(
    .LANES(LANES), .LINE_W(LINE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_line(txn_line), .txn_lanes(txn_lanes), .lane_offset(lane_offset),
    .done(done), .txn_count(txn_count)
);

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1023:0] req_addr = '0;
    logic [31:0]   req_mask = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [24:0]   txn_line;
    logic [31:0]   txn_lanes;
    logic [223:0]  lane_offset;
    logic          done;
    logic [5:0]    txn_count;

    int errors = 0;
    int checks = 0;
    logic [31:0] a [32];

    always #10 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_line(txn_line), .txn_lanes(txn_lanes),
        .lane_offset(lane_offset), .done(done), .txn_count(txn_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] mask, input int stall, input string cnt_tag);
        logic [24:0] el [$];
        logic [31:0] em [$];
        logic [31:0] left, m;
        int lead, k, n;
        bit rdy, off_ok;
        left = mask;
        while (left != 0) begin
            lead = 0;
            for (int i = 31; i >= 0; i--) if (left[i]) lead = i;
            m = '0;
            for (int i = 0; i < 32; i++)
                if (left[i] && a[i][31:7] == a[lead][31:7]) m[i] = 1'b1;
            el.push_back(a[lead][31:7]);
            em.push_back(m);
            left &= ~m;
        end
        chk(req_ready === 1'b1, "R2 ready in idle", 64'(req_ready), 1);
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
        req_mask  = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~req_addr;
        req_mask  = ~req_mask;
        if (em.size() == 0) begin
            chk(done === 1'b1, "R8 empty done", 64'(done), 1);
            chk(txn_count === 6'd0, "R8 empty count", 64'(txn_count), 0);
            chk(txn_valid === 1'b0, "R8 empty no txn", 64'(txn_valid), 0);
        end else begin
            chk(req_ready === 1'b0, "R2 busy not ready", 64'(req_ready), 0);
            k = 0;
            n = 0;
            while (n < em.size()) begin
                off_ok = 1'b1;
                for (int i = 0; i < 32; i++)
                    if (lane_offset[i*7 +: 7] !== a[i][6:0]) off_ok = 1'b0;
                chk(off_ok, "R11 lane offsets", 64'(lane_offset[6:0]), 64'(a[0][6:0]));
                chk(txn_valid === 1'b1, "R12 txn valid", 64'(txn_valid), 1);
                chk(txn_line === el[n], "R3 R4 line order", 64'(txn_line), 64'(el[n]));
                chk(txn_lanes === em[n], "R3 lane mask", 64'(txn_lanes), 64'(em[n]));
                chk(done === 1'b0, "R10 no early done", 64'(done), 0);
                rdy = (stall == 0) ? 1'b1 : ((k % 3) != 1);
                txn_ready = rdy;
                k++;
                @(negedge clk);
                if (rdy) n++;
            end
            txn_ready = 1'b0;
            chk(done === 1'b1, "R10 done after last", 64'(done), 1);
            chk(txn_count === 6'(em.size()), cnt_tag, 64'(txn_count), 64'(em.size()));
            chk(txn_valid === 1'b0, "R10 no txn at done", 64'(txn_valid), 0);
            if (stall == 0)
                chk(k == em.size(), "R12 cycles", 64'(k), 64'(em.size()));
        end
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 64'(done), 0);
        chk(req_ready === 1'b1, "R10 back to idle", 64'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0,
            "R1 reset state", {61'd0, req_ready, txn_valid, done}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0,
            "R1 after reset", {61'd0, req_ready, txn_valid, done}, 64'h4);

        for (int i = 0; i < 32; i++) a[i] = 32'h0000_1000 + i * 4;
        run_req(32'hFFFF_FFFF, 0, "R5 consecutive count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0004_2080 + ((i * 7) % 32) * 4;
        run_req(32'hFFFF_FFFF, 1, "R5 permutation count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0000_3000 + i * 8;
        run_req(32'hFFFF_FFFF, 0, "R6 stride two count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0010_0000 + i * 4096 + i * 4;
        run_req(32'hFFFF_FFFF, 1, "R7 scattered count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0000_5000 + i * 4096;
        run_req(32'h0000_0000, 0, "R8 empty");

        for (int i = 0; i < 32; i++) a[i] = (i < 16) ? 32'h0000_6000 + i * 4 : 32'h0900_0000 + i * 256;
        run_req(32'h0000_FFFF, 0, "R8 inactive lanes count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0000_7000 + ((2 - (i % 3)) * 128) + (i % 8) * 4;
        run_req(32'hFFFF_FFFF, 1, "R4 order count");

        for (int i = 0; i < 32; i++) a[i] = 32'h0000_8040 + i * 4;
        run_req(32'hAAAA_5555, 0, "R3 unaligned count");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule